// File: doc/BRIEF.md
# Masked Pattern Detector with Autoreset

This block sits on the result register of a wide accumulator. Each time the result register loads, the incoming value is compared against a reference pattern. Bit positions that a mask marks are ignored. Two registered flags come out of the compare: one for a match against the pattern and one for a match against the bitwise inverse of the pattern. Both flags always describe the value currently held in the result register.

The pattern and the mask are each taken either from a build-time constant or from the live `c_in` operand. This lets one instance watch for a fixed terminal count while another compares against a value that changes at run time. An optional autoreset mode forces the result register back to zero on the edge after a qualifying flag. The qualifying flag is either a match or a match that has just ended. The forced clear overrides the load enable. A build parameter can turn detection off entirely.

The autoreset controller is a two-state machine. `ST_IDLE` means the match flag was low before the most recent load. `ST_HIT` means it was high. Every load takes the transition `T_LOAD_HIT` into `ST_HIT` when the current match flag is high, or `T_LOAD_MISS` into `ST_IDLE` when it is low. Without a load the state holds (`T_HOLD`).

Top module: `pd_detect`

## Requirements
- R1: While `rst_n` is low, `p_q`, `match_q` and `match_inv_q` are all zero.
- R2: If `p_en` is high and no clear is pending, `p_q` takes `p_next` at the next rising edge. If `p_en` is low and no clear is pending, `p_q` and both flags keep their values.
- R3: `match_q` is high exactly when every bit of `p_q` whose mask bit is 0 equals the same bit of the pattern. A mask bit of 1 means that position is ignored.
- R4: `match_inv_q` is high exactly when every unmasked bit of `p_q` equals the inverse of the same pattern bit.
- R5: With `PAT_SRC = SRC_C`, the pattern is the value on `c_in` at the edge where the result register loads.
- R6: With `MASK_SRC = SRC_C`, the mask is the value on `c_in` at the edge where the result register loads.
- R7: With `AUTO_MODE = AR_ON_MATCH`, a high `match_q` makes `p_q` zero at the next edge regardless of `p_en`. The flags are then recomputed for the zero value.
- R8: With `AUTO_MODE = AR_ON_MISS`, when a load drops `match_q` from high to low, `p_q` becomes zero at the next edge regardless of `p_en`.
- R9: With `AUTO_MODE = AR_NONE`, the result register is never cleared by the detector.
- R10: With `DETECT_EN = 0`, both flags stay low and no autoreset happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_en | input | 1 | Load enable for the result register |
| p_next | input | W | Value to load into the result register |
| c_in | input | W | Operand used as pattern and/or mask when selected |
| p_q | output | W | Registered result |
| match_q | output | 1 | Registered pattern match flag for `p_q` |
| match_inv_q | output | 1 | Registered inverse-pattern match flag for `p_q` |

## Verification
The bench builds four instances at W = 48 that share one stimulus stream. The first uses a constant pattern 0x1234 with a mask that ignores the upper 32 bits and clears on match. This exercises masking, both flags and the match-triggered clear overriding a low enable. The second takes its pattern from `c_in` with an all-zero mask and clears when a match ends, which reaches the falling-edge clear and its repeat after a cleared zero matches again. The third takes its mask from `c_in` with no autoreset, and the fourth has detection disabled with a mask that would accept every value. Together they cover every source selection, every autoreset mode and the disabled case.

// File: rtl/pd_pkg.sv
package pd_pkg;

    // Where the pattern or mask comes from
    typedef enum logic {
        SRC_PARAM = 1'b0,
        SRC_C     = 1'b1
    } src_e;

    // Autoreset behaviour
    typedef enum logic [1:0] {
        AR_NONE     = 2'd0,
        AR_ON_MATCH = 2'd1,
        AR_ON_MISS  = 2'd2
    } autorst_e;

    // Autoreset controller state: match flag level before the latest load
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIT  = 1'b1
    } ar_state_e;

endpackage

// File: rtl/pd_compare.sv
module pd_compare
    import pd_pkg::*;
#(
    parameter int             W         = 48,
    parameter src_e           PAT_SRC   = SRC_PARAM,
    parameter src_e           MASK_SRC  = SRC_PARAM,
    parameter logic [W-1:0]   PATTERN   = '0,
    parameter logic [W-1:0]   MASK      = '0,
    parameter bit             DETECT_EN = 1'b1
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] c_val,
    output logic         hit,
    output logic         hit_inv
);

    logic [W-1:0] pat;
    logic [W-1:0] msk;
    logic [W-1:0] bit_ok;
    logic [W-1:0] bit_inv_ok;

    assign pat = (PAT_SRC  == SRC_C) ? c_val : PATTERN;
    assign msk = (MASK_SRC == SRC_C) ? c_val : MASK;

    // Per-bit agreement, forced true where the mask ignores the bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i]     = (value[i] ~^ pat[i]) | msk[i];
        assign bit_inv_ok[i] = (value[i] ^  pat[i]) | msk[i];
    end

    assign hit     = DETECT_EN && (&bit_ok);
    assign hit_inv = DETECT_EN && (&bit_inv_ok);

endmodule

// File: rtl/pd_autorst.sv
module pd_autorst
    import pd_pkg::*;
#(
    parameter autorst_e MODE = AR_NONE,
    parameter bit       EN   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic flag,
    output logic clear
);

    ar_state_e state;
    ar_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: T_LOAD_HIT, T_LOAD_MISS, T_HOLD
    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = flag ? ST_HIT : ST_IDLE;
        end
    end

    // Clear request
    always_comb begin
        clear = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clear = (MODE == AR_ON_MATCH) && flag;
            end
            ST_HIT: begin
                if (MODE == AR_ON_MATCH) begin
                    clear = flag;
                end else if (MODE == AR_ON_MISS) begin
                    clear = !flag;
                end
            end
        endcase
        clear = clear && EN;
    end

endmodule

// File: rtl/pd_detect.sv
module pd_detect
    import pd_pkg::*;
#(
    parameter int           W         = 48,
    parameter src_e         PAT_SRC   = SRC_PARAM,
    parameter src_e         MASK_SRC  = SRC_PARAM,
    parameter logic [W-1:0] PATTERN   = '0,
    parameter logic [W-1:0] MASK      = '0,
    parameter autorst_e     AUTO_MODE = AR_NONE,
    parameter bit           DETECT_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         p_en,
    input  logic [W-1:0] p_next,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] p_q,
    output logic         match_q,
    output logic         match_inv_q
);

    logic         clear;
    logic         load;
    logic [W-1:0] nv;
    logic         hit;
    logic         hit_inv;

    // Forced clear wins over the enable
    assign load = clear | p_en;
    assign nv   = clear ? '0 : p_next;

    pd_compare #(
        .W         (W),
        .PAT_SRC   (PAT_SRC),
        .MASK_SRC  (MASK_SRC),
        .PATTERN   (PATTERN),
        .MASK      (MASK),
        .DETECT_EN (DETECT_EN)
    ) u_cmp (
        .value   (nv),
        .c_val   (c_in),
        .hit     (hit),
        .hit_inv (hit_inv)
    );

    pd_autorst #(
        .MODE (AUTO_MODE),
        .EN   (DETECT_EN)
    ) u_ar (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .flag  (match_q),
        .clear (clear)
    );

    // Result and flags share one enable so they stay aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q         <= '0;
            match_q     <= 1'b0;
            match_inv_q <= 1'b0;
        end else if (load) begin
            p_q         <= nv;
            match_q     <= hit;
            match_inv_q <= hit_inv;
        end
    end

endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pd_pkg::*;
#(
    parameter int           W         = 48,
    parameter src_e         PAT_SRC   = SRC_PARAM,
    parameter src_e         MASK_SRC  = SRC_PARAM,
    parameter logic [W-1:0] PATTERN   = '0,
    parameter logic [W-1:0] MASK      = '0,
    parameter autorst_e     AUTO_MODE = AR_NONE,
    parameter bit           DETECT_EN = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         p_en,
    input logic [W-1:0] p_q,
    input logic         match_q,
    input logic         match_inv_q
);

    if (DETECT_EN && AUTO_MODE == AR_ON_MATCH) begin : g_on_match
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!p_en && !match_q) |=> $stable(p_q));
        assert_clear_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            match_q |=> (p_q == '0));
    end

    if (DETECT_EN && AUTO_MODE == AR_ON_MISS) begin : g_on_miss
        assert_clear_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(match_q) |=> (p_q == '0));
    end

    if (AUTO_MODE == AR_NONE || !DETECT_EN) begin : g_no_clear
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !p_en |=> ($stable(p_q) && $stable(match_q) && $stable(match_inv_q)));
    end

    if (!DETECT_EN) begin : g_off
        assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(match_q || match_inv_q));
    end

    if (DETECT_EN && PAT_SRC == SRC_PARAM && MASK_SRC == SRC_PARAM) begin : g_static
        assert_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
            match_q |-> (((p_q ~^ PATTERN) | MASK) == {W{1'b1}}));
        assert_inv_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            match_inv_q |-> (((p_q ^ PATTERN) | MASK) == {W{1'b1}}));
    end

endmodule

bind pd_detect pd_checker #(
    .W         (W),
    .PAT_SRC   (PAT_SRC),
    .MASK_SRC  (MASK_SRC),
    .PATTERN   (PATTERN),
    .MASK      (MASK),
    .AUTO_MODE (AUTO_MODE),
    .DETECT_EN (DETECT_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p_en        (p_en),
    .p_q         (p_q),
    .match_q     (match_q),
    .match_inv_q (match_inv_q)
);

// File: tb/pd_detect_bench.sv
module pd_detect_bench;
    import pd_pkg::*;

    localparam int W = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         p_en = 1'b0;
    logic [W-1:0] p_next = '0;
    logic [W-1:0] c_in = '0;

    always #5 clk = ~clk;   // 100 MHz

    logic [W-1:0] pq [4];
    logic         mq [4];
    logic         miq[4];

    // a: constant pattern/mask, clear on match
    pd_detect #(.W(W), .PAT_SRC(SRC_PARAM), .MASK_SRC(SRC_PARAM),
        .PATTERN(48'h0000_0000_1234), .MASK(48'hFFFF_FFFF_0000),
        .AUTO_MODE(AR_ON_MATCH), .DETECT_EN(1'b1)) u_pd_detect (
        .clk(clk), .rst_n(rst_n), .p_en(p_en), .p_next(p_next), .c_in(c_in),
        .p_q(pq[0]), .match_q(mq[0]), .match_inv_q(miq[0]));
    // b: pattern from c_in, mask zero, clear when a match ends
    pd_detect #(.W(W), .PAT_SRC(SRC_C), .MASK_SRC(SRC_PARAM),
        .PATTERN('0), .MASK('0),
        .AUTO_MODE(AR_ON_MISS), .DETECT_EN(1'b1)) u_pd_detect_b (
        .clk(clk), .rst_n(rst_n), .p_en(p_en), .p_next(p_next), .c_in(c_in),
        .p_q(pq[1]), .match_q(mq[1]), .match_inv_q(miq[1]));
    // c: mask from c_in, pattern zero, no autoreset
    pd_detect #(.W(W), .PAT_SRC(SRC_PARAM), .MASK_SRC(SRC_C),
        .PATTERN('0), .MASK('0),
        .AUTO_MODE(AR_NONE), .DETECT_EN(1'b1)) u_pd_detect_c (
        .clk(clk), .rst_n(rst_n), .p_en(p_en), .p_next(p_next), .c_in(c_in),
        .p_q(pq[2]), .match_q(mq[2]), .match_inv_q(miq[2]));
    // d: detection disabled, mask would accept everything
    pd_detect #(.W(W), .PAT_SRC(SRC_PARAM), .MASK_SRC(SRC_PARAM),
        .PATTERN('0), .MASK({W{1'b1}}),
        .AUTO_MODE(AR_ON_MATCH), .DETECT_EN(1'b0)) u_pd_detect_d (
        .clk(clk), .rst_n(rst_n), .p_en(p_en), .p_next(p_next), .c_in(c_in),
        .p_q(pq[3]), .match_q(mq[3]), .match_inv_q(miq[3]));

    typedef struct packed {
        logic [3:0][W-1:0] p;
        logic [3:0]        f;
        logic [3:0]        fi;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Reference state per instance
    logic [W-1:0] m_p   [4];
    bit           m_f   [4];
    bit           m_fi  [4];
    bit           m_prev[4];

    task automatic cfg(input int i, output bit pc, output bit mc, output autorst_e md,
                       output bit en, output logic [W-1:0] pat, output logic [W-1:0] msk);
        pc = 0; mc = 0; md = AR_NONE; en = 1; pat = '0; msk = '0;
        case (i)
            0: begin md = AR_ON_MATCH; pat = 48'h1234; msk = 48'hFFFF_FFFF_0000; end
            1: begin pc = 1; md = AR_ON_MISS; end
            2: begin mc = 1; end
            default: begin md = AR_ON_MATCH; en = 0; msk = {W{1'b1}}; end
        endcase
    endtask

    task automatic check(input string tag, input int i, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s inst %0d %s: actual %h expected %h", tag, i, what, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input bit en_in, input logic [W-1:0] nx, input logic [W-1:0] c,
                        input string tag);
        exp_t e;
        bit pc, mc, en, clr;
        autorst_e md;
        logic [W-1:0] pat, msk, v;
        @(negedge clk);
        #1;
        p_en = en_in; p_next = nx; c_in = c;
        for (int i = 0; i < 4; i++) begin
            cfg(i, pc, mc, md, en, pat, msk);
            if (pc) pat = c;
            if (mc) msk = c;
            clr = en && ((md == AR_ON_MATCH && m_f[i]) ||
                         (md == AR_ON_MISS && m_prev[i] && !m_f[i]));
            if (clr || en_in) begin
                v = clr ? '0 : nx;
                m_prev[i] = m_f[i];
                m_f[i]    = en && (((v ~^ pat) | msk) == {W{1'b1}});
                m_fi[i]   = en && (((v ^ pat) | msk) == {W{1'b1}});
                m_p[i]    = v;
            end
            e.p[i]  = m_p[i];
            e.f[i]  = m_f[i];
            e.fi[i] = m_fi[i];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare on the falling edge after the register update
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            for (int i = 0; i < 4; i++) begin
                check(t, i, "p_q", pq[i], e.p[i]);
                check(t, i, "match_q", {{(W-1){1'b0}}, mq[i]}, {{(W-1){1'b0}}, e.f[i]});
                check(t, i, "match_inv_q", {{(W-1){1'b0}}, miq[i]}, {{(W-1){1'b0}}, e.fi[i]});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_p[i] = '0; m_f[i] = 0; m_fi[i] = 0; m_prev[i] = 0;
        end
        #12;
        for (int i = 0; i < 4; i++) begin    // R1 reset state
            check("R1", i, "p_q", pq[i], '0);
            check("R1", i, "match_q", {{(W-1){1'b0}}, mq[i]}, '0);
            check("R1", i, "match_inv_q", {{(W-1){1'b0}}, miq[i]}, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 48'h1234, '0, "R2 R3 R10");                            // a matches, d stays quiet
        step(1, 48'h5555, '0, "R7");                                   // a cleared despite load
        step(1, 48'hABCD_0000_EDCB, '0, "R4");                         // a inverse match
        step(1, 48'h7777_0000_1234, 48'h7777_0000_1234, "R3 R5");      // masked upper, b pattern from c
        step(0, 48'h9999, 48'h7777_0000_1234, "R7 R2");                // a clear over low enable, others hold
        step(1, 48'h1111, 48'h7777_0000_1234, "R5 R8");                // b match ends
        step(0, 48'h2222, '0, "R8 R9");                                // b cleared, c holds
        step(1, 48'h3333, '0, "R8");
        step(1, 48'h4444, 48'h00FF, "R8 R6");                          // b cleared again
        step(1, 48'h00AB, 48'h00FF, "R6 R9");                          // c match via mask from c
        step(1, 48'hFFFF_FFFF_FF12, 48'h00FF, "R6 R4");                // c inverse match
        step(1, 48'h0100, 48'h00FF, "R6 R10");                         // c no match
        step(0, 48'h0, 48'h0, "R2 R9");

        for (int k = 0; k < 80; k++) begin                             // R3 R4 R5 R6 mixed
            logic [W-1:0] nx, c;
            bit en_in;
            en_in = ($urandom % 4) != 0;
            case ($urandom % 4)
                0: nx = 48'h1234;
                1: nx = ~48'h1234;
                2: nx = '0;
                default: nx = {$urandom, $urandom};
            endcase
            case ($urandom % 3)
                0: c = '0;
                1: c = nx;
                default: c = 48'h0000_0000_FFFF;
            endcase
            step(en_in, nx, c, "R3 R4 R5 R6 R7 R8");
        end

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule